// File: doc/BRIEF.md
# Packed Add-and-Narrow-High Unit

This block is one stage of a packed-integer datapath. It receives two 128-bit operands and adds them lane by lane, treating each operand as a set of wide lanes. For each lane it keeps only the upper half of the sum, and it packs those halves into a single 64-bit result. A 2-bit size code chooses the narrow element width at run time: 8, 16 or 32 bits. The matching wide lanes are 16, 32 or 64 bits, so the result holds 8, 4 or 2 lanes.

The unit also decodes the register fields of the operation. Each source index is a high bit joined to a 4-bit field, and the quad register it names is that 5-bit value shifted right by one. The destination index is used as given. Two kinds of encoding are rejected. The reserved size code belongs to a different operation. An odd low bit in either source field is undefined. In both cases the result is zeroed and no write is issued.

Inputs are taken when a valid strobe is high. Every output is registered and appears exactly one clock later. The unit has no sign mode, because a wrapping add gives the same bits for signed and unsigned data.

Top module: `addhn_unit`

## Requirements
- R1: With size code 00, result byte e (bits 8e+7..8e) is bits 15..8 of the 16-bit wrapping sum of operand N bits 16e+15..16e and operand M bits 16e+15..16e, for e from 0 to 7.
- R2: With size code 01, result halfword e (bits 16e+15..16e) is bits 31..16 of the 32-bit wrapping sum of the 32-bit lanes e of both operands, for e from 0 to 3.
- R3: With size code 10, result word e (bits 32e+31..32e) is bits 63..32 of the 64-bit wrapping sum of the 64-bit lanes e of both operands, for e from 0 to 1.
- R4: The narrowing truncates. The lower half of each wide sum has no rounding effect, and a carry out of the top of a wide lane is lost. For example, all-ones plus one yields 0 in that lane.
- R5: Size code 11 sets out_alias and clears out_undef, out_wen and out_result, whatever the index fields hold.
- R6: With a legal size code, a 1 in bit 0 of either 4-bit source field sets out_undef and clears out_wen and out_result. Otherwise out_undef is 0 and out_wen equals out_valid.
- R7: out_dst is {d_hi, d_idx}. out_qn is {n_hi, n_idx} shifted right by one, and out_qm is formed the same way from the M fields.
- R8: out_valid is high in the cycle after a cycle in which in_valid was high, and low after a cycle in which it was low.
- R9: A synchronous active-high reset clears out_valid and out_wen at the next edge, even if in_valid is high.
- R10: out_wen is never high while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for the inputs below |
| in_size | input | 2 | Narrow width code: 00=8, 01=16, 10=32, 11 reserved |
| in_n_hi | input | 1 | High bit of the first source index |
| in_n_idx | input | 4 | Low field of the first source index |
| in_m_hi | input | 1 | High bit of the second source index |
| in_m_idx | input | 4 | Low field of the second source index |
| in_d_hi | input | 1 | High bit of the destination index |
| in_d_idx | input | 4 | Low field of the destination index |
| in_opn | input | 128 | First packed operand |
| in_opm | input | 128 | Second packed operand |
| out_valid | output | 1 | Result registered from the previous cycle |
| out_wen | output | 1 | Destination write enable |
| out_undef | output | 1 | Odd source field with a legal size |
| out_alias | output | 1 | Reserved size code, belongs to another operation |
| out_dst | output | 5 | Destination index |
| out_qn | output | 4 | First source quad register |
| out_qm | output | 4 | Second source quad register |
| out_result | output | 64 | Packed narrowed result |

## Verification
On every cycle the assertions check the timing and gating rules. They check the one-cycle valid latency, the write enable and the zeroed result for rejected encodings, the precedence of the reserved size over the undefined flag, that the write enable stays low whenever valid is low, and the pass-through of the destination index. Only the bench scenarios can show the lane arithmetic for each width: the position of every narrowed half, the carries from low halves that reach the kept bits, and the loss of the carry out at each lane top. The bench compares these against a separately computed model using directed corner operands and random operands.

// File: rtl/addhn_pkg.sv
package addhn_pkg;

    // Narrow result width; the wide source width is derived from it.
    localparam int NARROW_W   = 64;
    localparam int WIDE_W     = 2 * NARROW_W;
    localparam int IDX_W      = 4;
    localparam int REG_W      = IDX_W + 1;
    localparam int SIZE_CODES = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef struct packed {
        logic             alias_op;
        logic             undef;
        logic [REG_W-1:0] dst;
        logic [IDX_W-1:0] qn;
        logic [IDX_W-1:0] qm;
    } dec_t;

    typedef struct packed {
        logic                valid;
        logic                wen;
        logic                undef;
        logic                alias_op;
        logic [REG_W-1:0]    dst;
        logic [IDX_W-1:0]    qn;
        logic [IDX_W-1:0]    qm;
        logic [NARROW_W-1:0] result;
    } stage_t;

endpackage

// File: rtl/addhn_decode.sv
module addhn_decode
    import addhn_pkg::*;
(
    input  logic [1:0]       size,
    input  logic             n_hi,
    input  logic [IDX_W-1:0] n_idx,
    input  logic             m_hi,
    input  logic [IDX_W-1:0] m_idx,
    input  logic             d_hi,
    input  logic [IDX_W-1:0] d_idx,
    output dec_t             dec
);

    logic             rsvd;
    logic             odd_src;
    logic [REG_W-1:0] n_full;
    logic [REG_W-1:0] m_full;

    always_comb begin
        n_full  = {n_hi, n_idx};
        m_full  = {m_hi, m_idx};
        rsvd    = (size_e'(size) == SZ_RSVD);
        odd_src = n_full[0] | m_full[0];

        // The reserved size is resolved first: it names another operation.
        dec.alias_op = rsvd;
        dec.undef    = !rsvd && odd_src;
        dec.dst      = {d_hi, d_idx};
        dec.qn       = n_full[REG_W-1:1];
        dec.qm       = m_full[REG_W-1:1];
    end

endmodule

// File: rtl/addhn_lanes.sv
module addhn_lanes
    import addhn_pkg::*;
#(
    parameter int NW = NARROW_W,
    parameter int NCODES = SIZE_CODES
) (
    input  logic [1:0]      size,
    input  logic [2*NW-1:0] opn,
    input  logic [2*NW-1:0] opm,
    output logic [NW-1:0]   narrowed
);

    logic [NW-1:0] per_size [NCODES];

    for (genvar s = 0; s < NCODES; s++) begin : g_size
        localparam int ESZ   = 8 << s;
        localparam int WSZ   = 2 * ESZ;
        localparam int LANES = NW / ESZ;
        logic [NW-1:0] packed_hi;

        for (genvar e = 0; e < LANES; e++) begin : g_lane
            // Wrapping wide add; only the upper half survives the cast.
            assign packed_hi[e*ESZ +: ESZ] =
                ESZ'((opn[e*WSZ +: WSZ] + opm[e*WSZ +: WSZ]) >> ESZ);
        end

        assign per_size[s] = packed_hi;
    end

    always_comb begin
        narrowed = '0;
        for (int s = 0; s < NCODES; s++) begin
            if (int'(size) == s) begin
                narrowed = per_size[s];
            end
        end
    end

endmodule

// File: rtl/addhn_unit.sv
module addhn_unit
    import addhn_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    in_size,
    input  logic          in_n_hi,
    input  logic [3:0]    in_n_idx,
    input  logic          in_m_hi,
    input  logic [3:0]    in_m_idx,
    input  logic          in_d_hi,
    input  logic [3:0]    in_d_idx,
    input  logic [127:0]  in_opn,
    input  logic [127:0]  in_opm,
    output logic          out_valid,
    output logic          out_wen,
    output logic          out_undef,
    output logic          out_alias,
    output logic [4:0]    out_dst,
    output logic [3:0]    out_qn,
    output logic [3:0]    out_qm,
    output logic [63:0]   out_result
);

    dec_t                dec;
    logic [NARROW_W-1:0] lane_res;
    stage_t              stage_d;
    stage_t              stage_q;

    addhn_decode u_decode (
        .size  (in_size),
        .n_hi  (in_n_hi),
        .n_idx (in_n_idx),
        .m_hi  (in_m_hi),
        .m_idx (in_m_idx),
        .d_hi  (in_d_hi),
        .d_idx (in_d_idx),
        .dec   (dec)
    );

    addhn_lanes #(
        .NW     (NARROW_W),
        .NCODES (SIZE_CODES)
    ) u_lanes (
        .size     (in_size),
        .opn      (in_opn),
        .opm      (in_opm),
        .narrowed (lane_res)
    );

    always_comb begin
        stage_d = '0;
        if (in_valid) begin
            stage_d.valid    = 1'b1;
            stage_d.alias_op = dec.alias_op;
            stage_d.undef    = dec.undef;
            stage_d.wen      = !(dec.alias_op || dec.undef);
            stage_d.dst      = dec.dst;
            stage_d.qn       = dec.qn;
            stage_d.qm       = dec.qm;
            stage_d.result   = stage_d.wen ? lane_res : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid  = stage_q.valid;
    assign out_wen    = stage_q.wen;
    assign out_undef  = stage_q.undef;
    assign out_alias  = stage_q.alias_op;
    assign out_dst    = stage_q.dst;
    assign out_qn     = stage_q.qn;
    assign out_qm     = stage_q.qm;
    assign out_result = stage_q.result;

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10
    wen_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_wen);

    // R5
    alias_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
        out_alias |-> (!out_wen && !out_undef && out_result == '0));

    // R5
    alias_from_size_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b11) |=> out_alias);

    // R6
    undef_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
        out_undef |-> (!out_wen && out_result == '0));

    // R6
    odd_field_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size != 2'b11 && (in_n_idx[0] || in_m_idx[0]))
        |=> out_undef);

    // R6
    legal_writes_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_undef && !out_alias) |-> out_wen);

    // R7
    dst_pass_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_dst == $past({in_d_hi, in_d_idx}));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_wen));

endmodule

// File: tb/addhn_unit_test.sv
module addhn_unit_test;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        v;
        logic        wen;
        logic        undef;
        logic        alias_op;
        logic [4:0]  dst;
        logic [3:0]  qn;
        logic [3:0]  qm;
        logic [63:0] res;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    in_size = '0;
    logic          in_n_hi = 1'b0;
    logic [3:0]    in_n_idx = '0;
    logic          in_m_hi = 1'b0;
    logic [3:0]    in_m_idx = '0;
    logic          in_d_hi = 1'b0;
    logic [3:0]    in_d_idx = '0;
    logic [127:0]  in_opn = '0;
    logic [127:0]  in_opm = '0;
    logic          out_valid;
    logic          out_wen;
    logic          out_undef;
    logic          out_alias;
    logic [4:0]    out_dst;
    logic [3:0]    out_qn;
    logic [3:0]    out_qm;
    logic [63:0]   out_result;

    int   checks = 0;
    int   errors = 0;
    bit   mon_en = 1'b0;
    exp_t sb [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    addhn_unit uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_size    (in_size),
        .in_n_hi    (in_n_hi),
        .in_n_idx   (in_n_idx),
        .in_m_hi    (in_m_hi),
        .in_m_idx   (in_m_idx),
        .in_d_hi    (in_d_hi),
        .in_d_idx   (in_d_idx),
        .in_opn     (in_opn),
        .in_opm     (in_opm),
        .out_valid  (out_valid),
        .out_wen    (out_wen),
        .out_undef  (out_undef),
        .out_alias  (out_alias),
        .out_dst    (out_dst),
        .out_qn     (out_qn),
        .out_qm     (out_qm),
        .out_result (out_result)
    );

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model_lanes(logic [1:0] sz, logic [127:0] a, logic [127:0] b);
        int esz;
        int wide;
        logic [127:0] wmask;
        logic [127:0] emask;
        logic [127:0] acc;
        logic [127:0] la;
        logic [127:0] lb;
        logic [127:0] s;
        esz   = 8 << sz;
        wide  = 2 * esz;
        wmask = (128'd1 << wide) - 128'd1;
        emask = (128'd1 << esz) - 128'd1;
        acc   = '0;
        for (int e = 0; e < 64 / esz; e++) begin
            la  = (a >> (e * wide)) & wmask;
            lb  = (b >> (e * wide)) & wmask;
            s   = (la + lb) & wmask;
            acc = acc | (((s >> esz) & emask) << (e * esz));
        end
        return acc[63:0];
    endfunction

    task automatic send(string tag, logic [1:0] sz, logic nh, logic [3:0] nf,
                        logic mh, logic [3:0] mf, logic dh, logic [3:0] df,
                        logic [127:0] a, logic [127:0] b);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_size  = sz;
        in_n_hi  = nh;
        in_n_idx = nf;
        in_m_hi  = mh;
        in_m_idx = mf;
        in_d_hi  = dh;
        in_d_idx = df;
        in_opn   = a;
        in_opm   = b;
        it.v        = 1'b1;
        it.alias_op = (sz == 2'b11);
        it.undef    = !it.alias_op && (nf[0] || mf[0]);
        it.wen      = !it.alias_op && !it.undef;
        it.dst      = {dh, df};
        it.qn       = {nh, nf[3:1]};
        it.qm       = {mh, mf[3:1]};
        it.res      = it.wen ? model_lanes(sz, a, b) : 64'd0;
        it.tag      = tag;
        sb.push_back(it);
    endtask

    task automatic idle();
        exp_t it;
        @(negedge clk);
        in_valid = 1'b0;
        in_opn   = {4{32'hDEADBEEF}};
        it.v        = 1'b0;
        it.wen      = 1'b0;
        it.undef    = 1'b0;
        it.alias_op = 1'b0;
        it.dst      = '0;
        it.qn       = '0;
        it.qm       = '0;
        it.res      = '0;
        it.tag      = "R8";
        sb.push_back(it);
    endtask

    // Monitor: compares one scoreboard entry per clock, just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_en && sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                check(it.tag, "out_valid R8", 64'(out_valid), 64'(it.v));
                check(it.tag, "out_wen R10", 64'(out_wen), 64'(it.wen));
                if (it.v) begin
                    check(it.tag, "out_alias R5", 64'(out_alias), 64'(it.alias_op));
                    check(it.tag, "out_undef R6", 64'(out_undef), 64'(it.undef));
                    check(it.tag, "out_result", out_result, it.res);
                    check(it.tag, "out_dst R7", 64'(out_dst), 64'(it.dst));
                    check(it.tag, "out_qn R7", 64'(out_qn), 64'(it.qn));
                    check(it.tag, "out_qm R7", 64'(out_qm), 64'(it.qm));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9", "out_valid in reset", 64'(out_valid), 64'd0);
        check("R9", "out_wen in reset", 64'(out_wen), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        mon_en = 1'b1;

        // R1: byte narrowing, directed then random
        send("R1", 2'b00, 1'b0, 4'd2, 1'b1, 4'd4, 1'b0, 4'd7,
             {8{16'h1234}}, {8{16'h0101}});
        send("R1", 2'b00, 1'b1, 4'd14, 1'b0, 4'd0, 1'b1, 4'd15,
             128'h0001_0203_0405_0607_0809_0A0B_0C0D_0E0F,
             128'hF0E0_D0C0_B0A0_9080_7060_5040_3020_1000);
        // R2: halfword narrowing
        send("R2", 2'b01, 1'b0, 4'd6, 1'b0, 4'd8, 1'b0, 4'd3,
             {4{32'h0001_8000}}, {4{32'h0002_8000}});
        // R3: word narrowing
        send("R3", 2'b10, 1'b1, 4'd10, 1'b1, 4'd12, 1'b1, 4'd1,
             {64'h0000_0001_FFFF_FFFF, 64'h1234_5678_0000_0000},
             {64'h0000_0000_0000_0001, 64'h1111_1111_8000_0000});
        idle();
        for (int i = 0; i < 24; i++) begin
            logic [1:0] sz;
            sz = 2'(i % 3);
            send(sz == 2'b00 ? "R1" : (sz == 2'b01 ? "R2" : "R3"), sz,
                 1'($urandom), {3'($urandom), 1'b0}, 1'($urandom), {3'($urandom), 1'b0},
                 1'($urandom), 4'($urandom),
                 {$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom});
            if (i % 5 == 0) idle();
        end

        // R4: carry out of a lane lost; low-half carry reaches kept bits
        send("R4", 2'b00, 1'b0, 4'd0, 1'b0, 4'd2, 1'b0, 4'd0,
             {8{16'hFFFF}}, {8{16'h0001}});
        send("R4", 2'b00, 1'b0, 4'd0, 1'b0, 4'd2, 1'b0, 4'd0,
             {8{16'h00FF}}, {8{16'h0001}});
        send("R4", 2'b01, 1'b0, 4'd0, 1'b0, 4'd2, 1'b0, 4'd0,
             {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}});
        send("R4", 2'b10, 1'b0, 4'd0, 1'b0, 4'd2, 1'b0, 4'd0,
             {2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'h0000_0000_0000_0001}});
        send("R4", 2'b10, 1'b0, 4'd0, 1'b0, 4'd2, 1'b0, 4'd0,
             {2{64'h0000_0000_FFFF_FFFF}}, {2{64'h0000_0000_0000_0001}});

        // R5: reserved size, with and without odd fields
        send("R5", 2'b11, 1'b0, 4'd2, 1'b0, 4'd4, 1'b1, 4'd9,
             {8{16'h7777}}, {8{16'h1111}});
        send("R5", 2'b11, 1'b1, 4'd3, 1'b0, 4'd5, 1'b0, 4'd9,
             {8{16'h7777}}, {8{16'h1111}});
        // R6: odd source fields
        send("R6", 2'b00, 1'b0, 4'd1, 1'b0, 4'd2, 1'b0, 4'd5,
             {8{16'h7777}}, {8{16'h1111}});
        send("R6", 2'b01, 1'b0, 4'd2, 1'b1, 4'd15, 1'b0, 4'd5,
             {8{16'h7777}}, {8{16'h1111}});
        send("R6", 2'b10, 1'b1, 4'd9, 1'b1, 4'd11, 1'b0, 4'd5,
             {8{16'h7777}}, {8{16'h1111}});
        // R7: extreme index fields
        send("R7", 2'b01, 1'b1, 4'd14, 1'b1, 4'd14, 1'b1, 4'd15,
             '0, '0);
        idle();
        idle();

        // R9: reset while a valid input is presented
        @(negedge clk);
        mon_en = 1'b0;
        sb.delete();
        rst = 1'b1;
        in_valid = 1'b1;
        in_size = 2'b00;
        in_n_idx = 4'd0;
        in_m_idx = 4'd0;
        @(negedge clk);
        check("R9", "out_valid after reset", 64'(out_valid), 64'd0);
        check("R9", "out_wen after reset", 64'(out_wen), 64'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R8", "out_valid idle after reset", 64'(out_valid), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule